// File: doc/BRIEF.md
# Quick-Pulse Byte Programming Sequencer

This block is a host-side controller that writes a contiguous range of bytes into a command-driven flash device. It uses closed-loop pulses. A single start request supplies the first and last address. The sequencer then walks the range one byte at a time and fetches each expected byte from a data source that is indexed by the current address. For every byte it repeats a programming attempt until a read-back comparison succeeds or the attempt budget runs out.

Each attempt is a fixed sequence of four bus cycles, with two timed waits inside it:

1. A set-up command write.
2. A write that carries the address and the data. A programming wait follows it.
3. A verify command write. A recovery wait follows it.
4. A read of the byte, which is compared with the expected value.

Both waits are counted in clock cycles. The flash side is reached through a simple request/acknowledge bus-cycle port. A supply-ready input holds off the first command until the programming supply is available.

At the end of a run the sequencer always writes the read-mode command. It then pulses either its completion output or its error output for one cycle. On an error it keeps the failing address on an output.

Top module: `qpulse_prog_seq`

## Requirements
- R1: After reset, `busReq`, `busy`, `done` and `progErr` are 0 and `failAddr` is 0.
- R2: A `startReq` seen while `busy` is 0 latches `startAddr` and `endAddr` and raises `busy` on the next cycle. A `startReq` while `busy` is 1 has no effect on the bus traffic of the run in progress.
- R3: After a start is accepted, no bus request is made while `supplyReady` is 0.
- R4: While `busReq` is 1 and `busAck` is 0, the request stays asserted with `busWrite`, `busAddr` and `busWData` unchanged. A bus cycle completes in the cycle `busAck` is 1.
- R5: Each attempt issues these bus cycles, in this order:
  1. Write 8'h40.
  2. Write the expected byte at the current address.
  3. Exactly `PULSE_CYC` cycles with no request, then write 8'hC0.
  4. Exactly `RECOV_CYC` cycles with no request, then a read (`busWrite` = 0) at the current address.
- R6: A read-back that differs from the expected byte starts a new attempt on the same address. The attempt count is cleared for every new byte, so each byte may use up to `MAX_PULSES` attempts, independently of earlier bytes.
- R7: A matching read-back moves on to the next address. After the byte at `endAddr` matches, the sequencer writes 8'h00 and then ends the run with a `done` pulse.
- R8: When attempt number `MAX_PULSES` on a byte fails, the sequencer writes 8'h00 and ends with a `progErr` pulse. `failAddr` then shows that byte's address, and no later byte of the range is touched.
- R9: `done` and `progErr` are one cycle wide and never high together. The pulse appears in the cycle after the acknowledge of the final 8'h00 write.
- R10: `failAddr` changes only together with a `progErr` pulse. It keeps its value through later successful runs.
- R11: `busy` is 1 from the cycle after an accepted start up to the ending pulse, and it is 0 in the cycle of that pulse. `busReq` is never 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start a run (taken only when idle) |
| startAddr | input | AW | First address of the range |
| endAddr | input | AW | Last address of the range (not below startAddr) |
| supplyReady | input | 1 | Programming supply is up |
| srcAddr | output | AW | Address whose expected byte is wanted |
| srcData | input | 8 | Expected byte for srcAddr, combinational |
| busReq | output | 1 | Bus cycle request |
| busWrite | output | 1 | 1 = write cycle, 0 = read cycle |
| busAddr | output | AW | Bus cycle address |
| busWData | output | 8 | Write data or command byte |
| busAck | input | 1 | Bus cycle completes this clock |
| busRData | input | 8 | Read data, valid with busAck |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse: range programmed |
| progErr | output | 1 | One-cycle pulse: a byte exhausted its attempts |
| failAddr | output | AW | Address of the last byte that failed |

## Verification
The state of this block shows up almost entirely as bus traffic, so each corrupted piece of state has a visible symptom:

- A wrong sequencer state appears at the very next handshake, as an out-of-order command byte or read.
- A wrong timer value shifts the number of idle cycles before the verify write or the read, and the bench measures that gap on every attempt.
- A wrong attempt count or a count that is not cleared shows as too many or too few attempts on a byte before the exit write.
- A wrong address register shows at the next data write or read, or as a wrong `failAddr` in the cycle of the error pulse.

// File: rtl/qpulse_pkg.sv
`timescale 1ns/1ps
package qpulse_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_SETUP_PROG  = 8'h40;
  localparam logic [BYTE_W-1:0] CMD_PROG_VERIFY = 8'hC0;
  localparam logic [BYTE_W-1:0] CMD_READ_ARRAY  = 8'h00;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT_SUP,
    ST_SETUP,
    ST_PROG,
    ST_PULSE,
    ST_VERIFY,
    ST_RECOV,
    ST_READ,
    ST_EXIT
  } seqState_t;

  typedef enum logic [1:0] {
    WSEL_SETUP,
    WSEL_DATA,
    WSEL_VERIFY,
    WSEL_READMODE
  } wrSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   loadRange;
    logic   clrPulse;
    logic   incPulse;
    logic   incAddr;
    logic   loadPulseTmr;
    logic   loadRecovTmr;
    logic   tickTmr;
    logic   latchFail;
    wrSel_t wrSel;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic tmrZero;
    logic atEnd;
    logic pulseLast;
    logic dataMatch;
  } dpStat_t;

endpackage

// File: rtl/qpulse_dpath.sv
`timescale 1ns/1ps
module qpulse_dpath
  import qpulse_pkg::*;
#(
  parameter int AW         = 17,
  parameter int PULSE_CYC  = 1250,
  parameter int RECOV_CYC  = 750,
  parameter int MAX_PULSES = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  output dpStat_t           stat,
  input  logic [AW-1:0]     startAddr,
  input  logic [AW-1:0]     endAddr,
  input  logic [BYTE_W-1:0] srcData,
  input  logic [BYTE_W-1:0] busRData,
  output logic [AW-1:0]     busAddr,
  output logic [BYTE_W-1:0] busWData,
  output logic [AW-1:0]     srcAddr,
  output logic [AW-1:0]     failAddr
);

  localparam int LONGEST = (PULSE_CYC > RECOV_CYC) ? PULSE_CYC : RECOV_CYC;
  localparam int TW      = $clog2(LONGEST + 1);
  localparam int PW      = $clog2(MAX_PULSES + 1);
  localparam logic [TW-1:0] PULSE_LOAD = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] RECOV_LOAD = TW'(RECOV_CYC - 1);
  localparam logic [PW-1:0] LAST_TRY   = PW'(MAX_PULSES - 1);

  logic [AW-1:0] curAddr;
  logic [AW-1:0] lastAddr;
  logic [PW-1:0] pulseCnt;
  logic [TW-1:0] tmr;
  logic [AW-1:0] failAddrQ;

  // address walk over the latched range
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      lastAddr <= '0;
    end else if (ctrl.loadRange) begin
      curAddr  <= startAddr;
      lastAddr <= endAddr;
    end else if (ctrl.incAddr) begin
      curAddr  <= curAddr + AW'(1);
    end
  end

  // attempts spent on the current byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (ctrl.clrPulse) begin
      pulseCnt <= '0;
    end else if (ctrl.incPulse) begin
      pulseCnt <= pulseCnt + PW'(1);
    end
  end

  // shared down-counter for the programming and recovery waits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (ctrl.loadPulseTmr) begin
      tmr <= PULSE_LOAD;
    end else if (ctrl.loadRecovTmr) begin
      tmr <= RECOV_LOAD;
    end else if (ctrl.tickTmr) begin
      tmr <= tmr - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failAddrQ <= '0;
    end else if (ctrl.latchFail) begin
      failAddrQ <= curAddr;
    end
  end

  always_comb begin
    unique case (ctrl.wrSel)
      WSEL_SETUP:    busWData = CMD_SETUP_PROG;
      WSEL_DATA:     busWData = srcData;
      WSEL_VERIFY:   busWData = CMD_PROG_VERIFY;
      WSEL_READMODE: busWData = CMD_READ_ARRAY;
      default:       busWData = CMD_READ_ARRAY;
    endcase
  end

  assign busAddr  = curAddr;
  assign srcAddr  = curAddr;
  assign failAddr = failAddrQ;

  assign stat.tmrZero   = (tmr == '0);
  assign stat.atEnd     = (curAddr == lastAddr);
  assign stat.pulseLast = (pulseCnt == LAST_TRY);
  assign stat.dataMatch = (busRData == srcData);

endmodule

// File: rtl/qpulse_ctrl.sv
`timescale 1ns/1ps
module qpulse_ctrl
  import qpulse_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    supplyReady,
  input  logic    busAck,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    busReq,
  output logic    busWrite,
  output logic    busy,
  output logic    done,
  output logic    progErr
);

  seqState_t state;
  seqState_t stateNext;
  logic      errPend;
  logic      errPendNext;
  logic      doneNext;
  logic      progErrNext;

  always_comb begin
    stateNext   = state;
    errPendNext = errPend;
    doneNext    = 1'b0;
    progErrNext = 1'b0;
    ctrl        = '0;
    ctrl.wrSel  = WSEL_SETUP;
    busReq      = 1'b0;
    busWrite    = 1'b0;

    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          ctrl.loadRange = 1'b1;
          stateNext      = ST_WAIT_SUP;
        end
      end

      ST_WAIT_SUP: begin
        if (supplyReady) begin
          ctrl.clrPulse = 1'b1;
          stateNext     = ST_SETUP;
        end
      end

      ST_SETUP: begin
        busReq     = 1'b1;
        busWrite   = 1'b1;
        ctrl.wrSel = WSEL_SETUP;
        if (busAck) stateNext = ST_PROG;
      end

      ST_PROG: begin
        busReq     = 1'b1;
        busWrite   = 1'b1;
        ctrl.wrSel = WSEL_DATA;
        if (busAck) begin
          ctrl.loadPulseTmr = 1'b1;
          stateNext         = ST_PULSE;
        end
      end

      ST_PULSE: begin
        if (stat.tmrZero) stateNext = ST_VERIFY;
        else              ctrl.tickTmr = 1'b1;
      end

      ST_VERIFY: begin
        busReq     = 1'b1;
        busWrite   = 1'b1;
        ctrl.wrSel = WSEL_VERIFY;
        if (busAck) begin
          ctrl.loadRecovTmr = 1'b1;
          stateNext         = ST_RECOV;
        end
      end

      ST_RECOV: begin
        if (stat.tmrZero) stateNext = ST_READ;
        else              ctrl.tickTmr = 1'b1;
      end

      ST_READ: begin
        busReq = 1'b1;
        if (busAck) begin
          if (stat.dataMatch) begin
            if (stat.atEnd) begin
              errPendNext = 1'b0;
              stateNext   = ST_EXIT;
            end else begin
              ctrl.incAddr  = 1'b1;
              ctrl.clrPulse = 1'b1;
              stateNext     = ST_SETUP;
            end
          end else if (stat.pulseLast) begin
            errPendNext = 1'b1;
            stateNext   = ST_EXIT;
          end else begin
            ctrl.incPulse = 1'b1;
            stateNext     = ST_SETUP;
          end
        end
      end

      ST_EXIT: begin
        busReq     = 1'b1;
        busWrite   = 1'b1;
        ctrl.wrSel = WSEL_READMODE;
        if (busAck) begin
          ctrl.latchFail = errPend;
          doneNext       = !errPend;
          progErrNext    = errPend;
          stateNext      = ST_IDLE;
        end
      end

      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      errPend <= 1'b0;
      done    <= 1'b0;
      progErr <= 1'b0;
    end else begin
      state   <= stateNext;
      errPend <= errPendNext;
      done    <= doneNext;
      progErr <= progErrNext;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/qpulse_prog_seq.sv
`timescale 1ns/1ps
module qpulse_prog_seq
  import qpulse_pkg::*;
#(
  parameter int AW         = 17,
  parameter int PULSE_CYC  = 1250,
  parameter int RECOV_CYC  = 750,
  parameter int MAX_PULSES = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [AW-1:0]     startAddr,
  input  logic [AW-1:0]     endAddr,
  input  logic              supplyReady,
  output logic [AW-1:0]     srcAddr,
  input  logic [BYTE_W-1:0] srcData,
  output logic              busReq,
  output logic              busWrite,
  output logic [AW-1:0]     busAddr,
  output logic [BYTE_W-1:0] busWData,
  input  logic              busAck,
  input  logic [BYTE_W-1:0] busRData,
  output logic              busy,
  output logic              done,
  output logic              progErr,
  output logic [AW-1:0]     failAddr
);

  dpCtrl_t dpCtrl;
  dpStat_t dpStat;

  qpulse_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .supplyReady (supplyReady),
    .busAck      (busAck),
    .stat        (dpStat),
    .ctrl        (dpCtrl),
    .busReq      (busReq),
    .busWrite    (busWrite),
    .busy        (busy),
    .done        (done),
    .progErr     (progErr)
  );

  qpulse_dpath #(
    .AW         (AW),
    .PULSE_CYC  (PULSE_CYC),
    .RECOV_CYC  (RECOV_CYC),
    .MAX_PULSES (MAX_PULSES)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (dpCtrl),
    .stat      (dpStat),
    .startAddr (startAddr),
    .endAddr   (endAddr),
    .srcData   (srcData),
    .busRData  (busRData),
    .busAddr   (busAddr),
    .busWData  (busWData),
    .srcAddr   (srcAddr),
    .failAddr  (failAddr)
  );

endmodule

// File: rtl/qpulse_prog_seq_chk.sv
`timescale 1ns/1ps
module qpulse_prog_seq_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rstN,
  input logic          startReq,
  input logic          busReq,
  input logic          busWrite,
  input logic          busAck,
  input logic [AW-1:0] busAddr,
  input logic [7:0]    busWData,
  input logic          busy,
  input logic          done,
  input logic          progErr,
  input logic [AW-1:0] failAddr
);

  a_r2_start_accept: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> busy);

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> busReq);

  a_r4_fields_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> ($stable(busAddr) && $stable(busWData) && $stable(busWrite)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_err_single: assert property (@(posedge clk) disable iff (!rstN)
    progErr |=> !progErr);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(done && progErr));

  a_r10_fail_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(failAddr) |-> progErr);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busReq);

  a_r11_end_idle: assert property (@(posedge clk) disable iff (!rstN)
    (done || progErr) |-> !busy);

endmodule

bind qpulse_prog_seq qpulse_prog_seq_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .startReq (startReq),
  .busReq   (busReq),
  .busWrite (busWrite),
  .busAck   (busAck),
  .busAddr  (busAddr),
  .busWData (busWData),
  .busy     (busy),
  .done     (done),
  .progErr  (progErr),
  .failAddr (failAddr)
);

// File: tb/tb_qpulse_prog_seq.sv
`timescale 1ns/1ps
module tb_qpulse_prog_seq;

  localparam int AW    = 8;
  localparam int PCYC  = 12;
  localparam int RCYC  = 7;
  localparam int MAXP  = 25;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [AW-1:0] endAddr = '0;
  logic          supplyReady = 1'b0;
  logic [AW-1:0] srcAddr;
  logic [7:0]    srcData;
  logic          busReq, busWrite;
  logic [AW-1:0] busAddr;
  logic [7:0]    busWData;
  logic          busAck = 1'b0;
  logic [7:0]    busRData = '0;
  logic          busy, done, progErr;
  logic [AW-1:0] failAddr;

  always #4 clk = ~clk;

  function automatic logic [7:0] patByte(input logic [AW-1:0] a);
    return 8'(a * 8'd37 + 8'h5A);
  endfunction

  assign srcData = patByte(srcAddr);

  qpulse_prog_seq #(.AW(AW), .PULSE_CYC(PCYC), .RECOV_CYC(RCYC), .MAX_PULSES(MAXP)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startAddr(startAddr), .endAddr(endAddr),
    .supplyReady(supplyReady), .srcAddr(srcAddr), .srcData(srcData),
    .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr), .busWData(busWData),
    .busAck(busAck), .busRData(busRData), .busy(busy), .done(done),
    .progErr(progErr), .failAddr(failAddr));

  typedef struct {
    bit         wr;
    bit         chkAddr;
    bit         isExit;
    logic [7:0] addr;
    logic [7:0] data;
    int         gap;
  } xact_t;

  xact_t expQ[$];
  int tests = 0;
  int fails = 0;

  // flash model state
  int         needArr[256];
  int         pulseArr[256];
  bit         armed = 0;
  logic [7:0] lastA = '0;
  logic [7:0] lastD = '0;
  logic [7:0] verifyVal = '0;

  // reference bookkeeping
  bit         expErr = 0;
  logic [7:0] expFail = '0;
  bit         exitAckSeen = 0;
  bit         jobDone = 0;
  int         gap = 0;

  task automatic pushX(input bit wr, input bit chkA, input bit ex,
                       input logic [7:0] a, input logic [7:0] d, input int g);
    xact_t x;
    x.wr = wr; x.chkAddr = chkA; x.isExit = ex; x.addr = a; x.data = d; x.gap = g;
    expQ.push_back(x);
  endtask

  // Per-clock reference check and flash responder
  always @(negedge clk) begin
    if (rstN) begin
      if (exitAckSeen) begin
        tests++;
        if (done !== !expErr || progErr !== expErr) begin
          fails++;
          $display("FAIL R9 end pulse: done=%0b progErr=%0b expected done=%0b progErr=%0b",
                   done, progErr, !expErr, expErr);
        end
        tests++;
        if (busy !== 1'b0) begin
          fails++;
          $display("FAIL R11 busy at end pulse: %0b expected 0", busy);
        end
        if (expErr) begin
          tests++;
          if (failAddr !== expFail) begin
            fails++;
            $display("FAIL R8 failAddr: %h expected %h", failAddr, expFail);
          end
        end
        exitAckSeen = 0;
        jobDone = 1;
      end else if (done || progErr) begin
        fails++;
        $display("FAIL R9 stray pulse: done=%0b progErr=%0b expected 0/0", done, progErr);
      end

      if (!supplyReady && busReq) begin
        fails++;
        $display("FAIL R3 request while supply low: busReq=%0b expected 0", busReq);
      end

      if (busAck) begin
        busAck = 1'b0;
        if (!busReq) gap++;
      end else if (busReq) begin
        xact_t e;
        tests++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R7 unexpected bus cycle: wr=%0b addr=%h data=%h expected none",
                   busWrite, busAddr, busWData);
        end else begin
          e = expQ.pop_front();
          if (busWrite !== e.wr || (e.wr && busWData !== e.data) ||
              (e.chkAddr && busAddr !== e.addr)) begin
            fails++;
            $display("FAIL R5 bus cycle: wr=%0b addr=%h data=%h expected wr=%0b addr=%h data=%h",
                     busWrite, busAddr, busWData, e.wr, e.addr, e.data);
          end
          if (e.gap >= 0 && gap != e.gap) begin
            fails++;
            $display("FAIL R5 wait length: %0d idle cycles expected %0d", gap, e.gap);
          end
          exitAckSeen = e.isExit;
        end
        // flash behaviour
        if (busWrite) begin
          if (armed) begin
            lastA = busAddr; lastD = busWData;
            pulseArr[busAddr]++;
            armed = 0;
          end else if (busWData == 8'h40) begin
            armed = 1;
          end else if (busWData == 8'hC0) begin
            verifyVal = (pulseArr[lastA] >= needArr[lastA]) ? lastD : (lastD ^ 8'h80);
          end else begin
            armed = 0;
          end
        end else begin
          busRData = verifyVal;
        end
        busAck = 1'b1;
        gap = 0;
      end else begin
        gap++;
      end
    end
  end

  task automatic runJob(input logic [7:0] s, input logic [7:0] e, input bit midStart);
    int wd;
    expErr = 0;
    for (int i = 0; i < 256; i++) pulseArr[i] = 0;
    for (int a = s; a <= e; a++) begin
      int n = needArr[a];
      int tries = (n > MAXP) ? MAXP : n;
      for (int t = 0; t < tries; t++) begin
        pushX(1, 0, 0, 8'(a), 8'h40, -1);
        pushX(1, 1, 0, 8'(a), patByte(8'(a)), -1);
        pushX(1, 0, 0, 8'(a), 8'hC0, PCYC);
        pushX(0, 1, 0, 8'(a), 8'h00, RCYC);
      end
      if (n > MAXP) begin
        expErr = 1;
        expFail = 8'(a);
        break;
      end
    end
    pushX(1, 0, 1, 8'h00, 8'h00, -1);
    jobDone = 0;
    supplyReady = 1'b0;
    @(negedge clk);
    startAddr = s; endAddr = e; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    tests++;
    if (busy !== 1'b1) begin
      fails++;
      $display("FAIL R2 busy after start: %0b expected 1", busy);
    end
    // R3: supply held low, nothing may be requested
    for (int k = 0; k < 6; k++) @(negedge clk);
    tests++;
    if (expQ.size() == 0 || expQ[0].data !== 8'h40) begin
      fails++;
      $display("FAIL R3 traffic before supply ready: queue head consumed, expected untouched");
    end
    supplyReady = 1'b1;
    if (midStart) begin
      for (int k = 0; k < 40; k++) @(negedge clk);
      startAddr = 8'hE0; endAddr = 8'hE1; startReq = 1'b1;  // R2: must be ignored
      @(negedge clk);
      startReq = 1'b0;
    end
    wd = 0;
    while (!jobDone && wd < 20000) begin
      @(negedge clk);
      wd++;
    end
    if (!jobDone) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not end, %0d cycles expected end", wd);
    end
    tests++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R7 missing bus cycles: %0d left expected 0", expQ.size());
      expQ.delete();
    end
    for (int k = 0; k < 5; k++) @(negedge clk);
    tests++;
    if (busReq !== 1'b0 || busy !== 1'b0) begin
      fails++;
      $display("FAIL R11 idle after run: busReq=%0b busy=%0b expected 0/0", busReq, busy);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) needArr[i] = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    tests++;
    if (busReq !== 1'b0 || busy !== 1'b0 || done !== 1'b0 || progErr !== 1'b0 || failAddr !== '0) begin
      fails++;
      $display("FAIL R1 reset: busReq=%0b busy=%0b done=%0b progErr=%0b failAddr=%h expected 0",
               busReq, busy, done, progErr, failAddr);
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R5/R7/R2: several bytes with a few retries and an ignored second start
    needArr[8'h10] = 1; needArr[8'h11] = 1; needArr[8'h12] = 2; needArr[8'h13] = 3;
    runJob(8'h10, 8'h13, 1);

    // R6: 25 attempts on one byte succeeds, then the count restarts for the next
    needArr[8'h20] = 25; needArr[8'h21] = 20;
    runJob(8'h20, 8'h21, 0);

    // R8: middle byte never verifies, last byte untouched
    needArr[8'h30] = 1; needArr[8'h31] = 26; needArr[8'h32] = 1;
    runJob(8'h30, 8'h32, 0);

    // R10: a successful run leaves failAddr unchanged
    needArr[8'h40] = 1;
    runJob(8'h40, 8'h40, 0);
    tests++;
    if (failAddr !== 8'h31) begin
      fails++;
      $display("FAIL R10 failAddr after good run: %h expected 31", failAddr);
    end

    // R8: single-byte range that fails
    needArr[8'h50] = 40;
    runJob(8'h50, 8'h50, 0);
    tests++;
    if (failAddr !== 8'h50) begin
      fails++;
      $display("FAIL R10 failAddr updated: %h expected 50", failAddr);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule